// File: doc/BRIEF.md
# Tunable Harmonic Sine/Cosine Reference Generator

This block makes the sine and cosine references that an adaptive grid-voltage estimator needs. It covers the fundamental and every harmonic up to order 32. A 32-bit phase accumulator advances by a tuning word once per 1 µs tick. The tick is made by dividing the 100 MHz system clock by 100. At reset the tuning word is set to the value for 60 Hz. An external frequency-locking loop supplies a signed frequency error. Once every ten ticks the block scales that error by a fixed loop gain of 3, adds it to the word, and clamps the result to a programmable inclusive range. This keeps a large error from pushing the reference out of band.

After each tick a sequencer walks through harmonic orders 1 to 32, one per clock. For order k it forms the harmonic phase k times the 15-bit base phase, modulo 2^15. It does this with a running sum, not a multiplier. It emits one sine/cosine pair per clock with the order number and a valid strobe. The sine function spans a 2^15-step period. It is built from a quarter-wave table that is computed at elaboration time and interpolated linearly on the low address bits. Cosine is the same lookup with a quarter period, 2^13, added to the address. The design assumes that the harmonic count is smaller than the tick divider and that the lower clamp bound is not above the upper one.

Top module: `dds_ref_gen`

## Requirements
- R1: `tick_o` is high for exactly one clock in every 100. Its first high clock follows the 100th rising edge after reset is released.
- R2: On each tick the 32-bit accumulator adds the current tuning word, modulo 2^32. The base phase is bits [31:17] of the new accumulator value.
- R3: While reset is asserted, `ftw_o` is 257698, which is round(60 Hz · 1 µs · 2^32). `tick_o`, `valid_o`, `order_o`, `sin_o` and `cos_o` are all 0.
- R4: On every 10th tick the tuning word becomes its old value plus 3·`ferr_i`, with `ferr_i` signed two's complement. The accumulator step on that same tick uses the old word. `ferr_i` has no effect on any other clock.
- R5: The updated word is clamped to the inclusive range [`ftw_min_i`, `ftw_max_i`], both unsigned.
- R6: On the 32 clocks that follow each `tick_o` clock, `valid_o` is high and `order_o` counts 1, 2, …, 32.
- R7: For order k the harmonic phase is p = k·base mod 2^15. `sin_o` equals round(131071·sin(2π·p/2^15)) and `cos_o` equals the same for p+2^13, both within ±4 LSB as 18-bit two's complement.
- R8: `valid_o` is low on every clock not covered by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ferr_i | input | 24 | Signed frequency error from the locking loop |
| ftw_min_i | input | 32 | Lower bound of the tuning word |
| ftw_max_i | input | 32 | Upper bound of the tuning word |
| tick_o | output | 1 | One-clock pulse for each accumulator step |
| ftw_o | output | 32 | Current tuning word |
| valid_o | output | 1 | Reference pair strobe |
| order_o | output | 6 | Harmonic order of the current pair |
| sin_o | output | 18 | Signed sine sample |
| cos_o | output | 18 | Signed cosine sample |

## Verification
The bench drives the error input into both clamp bounds. A design that compared against the range before adding the gained error, or that clamped only one side, would leave the word out of band. The bench also widens the range so the base phase grows into the thousands and order-32 phases wrap modulo 2^15 many times. A harmonic phase register that is too narrow, or that restarts from zero instead of from the base, would produce wrong values only at high orders. The error input is changed on every clock between updates, and the bench compares the word on every clock, to catch a design that samples the error on the wrong tick or that applies an update before the accumulator step it shares a tick with. Quadrant boundaries are reached at every order, which exposes an off-by-one in the table mirroring as a full-scale error near 90° and 270°.

// File: rtl/dds_ref_pkg.sv
package dds_ref_pkg;

  // pi/2 in Q30
  localparam longint PI_HALF_Q30 = 64'sd1686629713;

  // quarter-wave sample i of 2^tbl_log, scaled to full signed data_w range
  function automatic longint sine_q(input int i, input int tbl_log, input int data_w);
    longint x, term, sum, t, amp;
    x    = (longint'(i) * PI_HALF_Q30) >>> tbl_log;
    term = x;
    sum  = 0;
    for (int n = 0; n < 12; n++) begin
      sum  = sum + term;
      t    = (term * x) >>> 30;
      t    = (t * x) >>> 30;
      term = -t / longint'((2 * n + 2) * (2 * n + 3));
    end
    if (sum < 0) sum = 0;
    amp = (64'sd1 <<< (data_w - 1)) - 1;
    return (sum * amp + (64'sd1 <<< 29)) >>> 30;
  endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/ref_ftw_ctl.sv
module ref_ftw_ctl #(
  parameter int                 ACC_W     = 32,
  parameter int                 ERR_W     = 24,
  parameter int                 UPD_TICKS = 10,
  parameter int                 GAIN      = 3,
  parameter logic [ACC_W-1:0]   NOM       = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [ERR_W-1:0] ferr_i,
  input  logic [ACC_W-1:0]        ftw_min_i,
  input  logic [ACC_W-1:0]        ftw_max_i,
  output logic [ACC_W-1:0]        ftw_o
);
  localparam int UW    = (UPD_TICKS > 1) ? $clog2(UPD_TICKS) : 1;
  localparam int SUM_W = ACC_W + ERR_W + 4;

  logic [UW-1:0]           upd_q;
  logic [ACC_W-1:0]        ftw_q;
  logic                    fire;
  logic signed [SUM_W-1:0] corr, sum, lo, hi;

  assign fire  = tick_i && (upd_q == UW'(UPD_TICKS - 1));
  assign corr  = SUM_W'(ferr_i) * $signed(SUM_W'(GAIN));
  assign sum   = $signed({{(SUM_W-ACC_W){1'b0}}, ftw_q}) + corr;
  assign lo    = $signed({{(SUM_W-ACC_W){1'b0}}, ftw_min_i});
  assign hi    = $signed({{(SUM_W-ACC_W){1'b0}}, ftw_max_i});
  assign ftw_o = ftw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= '0;
      ftw_q <= NOM;
    end else if (tick_i) begin
      upd_q <= fire ? '0 : upd_q + 1'b1;
      if (fire) begin
        if (sum < lo)      ftw_q <= ftw_min_i;
        else if (sum > hi) ftw_q <= ftw_max_i;
        else               ftw_q <= sum[ACC_W-1:0];
      end
    end
  end

  // R4
  ftw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(ftw_q));

  // R5
  ftw_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (ftw_q >= $past(ftw_min_i)) && (ftw_q <= $past(ftw_max_i)));

endmodule

// File: rtl/ref_sine_lut.sv
module ref_sine_lut
  import dds_ref_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 18,
  parameter int TBL_LOG = 8
) (
  input  logic [ADDR_W-1:0]        addr_i,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int QN     = 1 << TBL_LOG;
  localparam int FRAC_W = ADDR_W - 2 - TBL_LOG;
  localparam int QTR    = 1 << (ADDR_W - 2);

  logic signed [DATA_W-1:0] tbl [QN+2];

  for (genvar g = 0; g < QN + 2; g++) begin : g_tbl
    assign tbl[g] = DATA_W'(sine_q(g, TBL_LOG, DATA_W));
  end

  logic [1:0]               quad;
  logic [ADDR_W-3:0]        low;
  logic [ADDR_W-2:0]        mir;
  logic [TBL_LOG:0]         coarse;
  logic [TBL_LOG+1:0]       nxt;
  logic signed [DATA_W-1:0] t0, t1, mag;

  assign quad   = addr_i[ADDR_W-1:ADDR_W-2];
  assign low    = addr_i[ADDR_W-3:0];
  assign mir    = quad[0] ? ((ADDR_W-1)'(QTR) - {1'b0, low}) : {1'b0, low};
  assign coarse = mir[ADDR_W-2:FRAC_W];
  assign nxt    = {1'b0, coarse} + 1'b1;
  assign t0     = tbl[coarse];
  assign t1     = tbl[nxt];

  if (FRAC_W > 0) begin : g_interp
    localparam int PW = DATA_W + FRAC_W + 2;
    logic [FRAC_W-1:0]    frac;
    logic signed [DATA_W:0] diff;
    logic signed [PW-1:0] prod;
    assign frac = mir[FRAC_W-1:0];
    assign diff = {t1[DATA_W-1], t1} - {t0[DATA_W-1], t0};
    assign prod = PW'(diff) * PW'($signed({1'b0, frac}));
    assign mag  = t0 + DATA_W'(prod >>> FRAC_W);
  end else begin : g_direct
    assign mag = t0;
  end

  assign data_o = quad[1] ? -mag : mag;

endmodule

// File: rtl/dds_ref_gen.sv
module dds_ref_gen #(
  parameter int ACC_W     = 32,
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 18,
  parameter int TBL_LOG   = 8,
  parameter int ERR_W     = 24,
  parameter int TICK_DIV  = 100,
  parameter int UPD_TICKS = 10,
  parameter int GAIN      = 3,
  parameter int HARM_N    = 32,
  parameter int F_NOM_HZ  = 60,
  parameter int TICK_HZ   = 1000000
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic signed [ERR_W-1:0]            ferr_i,
  input  logic [ACC_W-1:0]                   ftw_min_i,
  input  logic [ACC_W-1:0]                   ftw_max_i,
  output logic                               tick_o,
  output logic [ACC_W-1:0]                   ftw_o,
  output logic                               valid_o,
  output logic [$clog2(HARM_N+1)-1:0]        order_o,
  output logic signed [DATA_W-1:0]           sin_o,
  output logic signed [DATA_W-1:0]           cos_o
);
  localparam int ORD_W = $clog2(HARM_N + 1);
  localparam int QTR   = 1 << (ADDR_W - 2);
  localparam logic [ACC_W-1:0] NOM_FTW =
    ACC_W'(((longint'(F_NOM_HZ) << ACC_W) + longint'(TICK_HZ / 2)) / longint'(TICK_HZ));

  logic                     tick;
  logic [ACC_W-1:0]         ftw, phase_q, phase_nxt;
  logic [ADDR_W-1:0]        base_q, hp_q;
  logic [ORD_W-1:0]         ord_q;
  logic                     busy_q;
  logic signed [DATA_W-1:0] lut_val [2];

  ref_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ref_ftw_ctl #(
    .ACC_W     (ACC_W),
    .ERR_W     (ERR_W),
    .UPD_TICKS (UPD_TICKS),
    .GAIN      (GAIN),
    .NOM       (NOM_FTW)
  ) u_ftw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .ferr_i    (ferr_i),
    .ftw_min_i (ftw_min_i),
    .ftw_max_i (ftw_max_i),
    .ftw_o     (ftw)
  );

  // g=0 sine, g=1 cosine (quarter-period shift)
  for (genvar g = 0; g < 2; g++) begin : g_lut
    ref_sine_lut #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .TBL_LOG (TBL_LOG)
    ) u_lut (
      .addr_i (hp_q + ADDR_W'(g * QTR)),
      .data_o (lut_val[g])
    );
  end

  assign phase_nxt = phase_q + ftw;
  assign ftw_o     = ftw;

  // accumulator and harmonic sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      base_q  <= '0;
      hp_q    <= '0;
      ord_q   <= '0;
      busy_q  <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_nxt;
      base_q  <= phase_nxt[ACC_W-1 -: ADDR_W];
      hp_q    <= phase_nxt[ACC_W-1 -: ADDR_W];
      ord_q   <= ORD_W'(1);
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      hp_q  <= hp_q + base_q;
      ord_q <= ord_q + 1'b1;
      if (ord_q == ORD_W'(HARM_N)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_o  <= 1'b0;
      valid_o <= 1'b0;
      order_o <= '0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else begin
      tick_o  <= tick;
      valid_o <= busy_q;
      if (busy_q) begin
        order_o <= ord_q;
        sin_o   <= lut_val[0];
        cos_o   <= lut_val[1];
      end
    end
  end

  // R6
  seq_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> valid_o && (order_o == ORD_W'(1)));

  // R6
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (order_o != ORD_W'(HARM_N))) |=> valid_o && (order_o == $past(order_o) + 1'b1));

  // R8
  seq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (order_o == ORD_W'(HARM_N))) |=> !valid_o);

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> phase_q == $past(phase_q) + $past(ftw));

endmodule

// File: tb/dds_ref_gen_test.sv
module dds_ref_gen_test;
  localparam int    AMP = 131071;
  localparam int    NOM = 257698;
  localparam real   TWO_PI = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [23:0] ferr = '0;
  logic [31:0]        fmin = 32'd236223;
  logic [31:0]        fmax = 32'd279172;
  logic               tick, valid;
  logic [31:0]        ftw;
  logic [5:0]         order;
  logic signed [17:0] sin_v, cos_v;

  dds_ref_gen uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ferr_i    (ferr),
    .ftw_min_i (fmin),
    .ftw_max_i (fmax),
    .tick_o    (tick),
    .ftw_o     (ftw),
    .valid_o   (valid),
    .order_o   (order),
    .sin_o     (sin_v),
    .cos_o     (cos_v)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit run_chk = 1'b0;

  function automatic int ref_sine(input int p);
    real r;
    r = AMP * $sin(TWO_PI * p / 32768.0);
    return $rtoi((r >= 0.0) ? r + 0.5 : r - 0.5);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp, input longint tol);
    n_chk++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  longint m_phase = 0, m_ftw = NOM, nf;
  int     m_cnt = 0, m_upd = 0, m_left = 0, m_k = 0, m_base = 0, p;
  bit     e_tick = 0, e_valid = 0;
  int     e_ord = 0, e_sin = 0, e_cos = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ftw = NOM; m_cnt = 0; m_upd = 0; m_left = 0; m_k = 0;
      e_tick = 0; e_valid = 0;
    end else begin
      e_tick  = 0;
      e_valid = 0;
      if (m_left > 0) begin
        e_valid = 1;
        e_ord   = m_k;
        p       = (m_k * m_base) % 32768;
        e_sin   = ref_sine(p);
        e_cos   = ref_sine((p + 8192) % 32768);
        m_k++;
        m_left--;
      end
      if (m_cnt == 99) begin
        m_cnt   = 0;
        e_tick  = 1;
        m_phase = (m_phase + m_ftw) & 64'hFFFF_FFFF;
        m_base  = int'(m_phase >> 17);
        m_left  = 32;
        m_k     = 1;
        if (m_upd == 9) begin
          m_upd = 0;
          nf = m_ftw + 3 * longint'(ferr);
          if (nf < longint'(fmin)) nf = longint'(fmin);
          else if (nf > longint'(fmax)) nf = longint'(fmax);
          m_ftw = nf;
        end else m_upd++;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk("R1 tick", longint'(tick), longint'(e_tick), 0);
      chk(e_valid ? "R6 valid" : "R8 valid", longint'(valid), longint'(e_valid), 0);
      chk("R4 tuning word", longint'(ftw), m_ftw, 0);
      if (e_valid) begin
        chk("R6 order", longint'(order), longint'(e_ord), 0);
        chk((e_ord == 1) ? "R2 base sine" : "R7 sine", longint'(sin_v), longint'(e_sin), 4);
        chk("R7 cosine", longint'(cos_v), longint'(e_cos), 4);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
    $finish;
  end

  task automatic step_in();
    @(posedge clk);
    #1;
  endtask

  task automatic run_ticks(input int n);
    repeat (n * 100) @(posedge clk);
    #1;
  endtask

  task automatic reset_checks();
    chk("R3 reset word", longint'(ftw), NOM, 0);
    chk("R3 reset valid", longint'(valid), 0, 0);
    chk("R3 reset tick", longint'(tick), 0, 0);
    chk("R3 reset order", longint'(order), 0, 0);
    chk("R3 reset sine", longint'(sin_v), 0, 0);
    chk("R3 reset cosine", longint'(cos_v), 0, 0);
  endtask

  int unsigned seed = 32'd12345;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    reset_checks();
    step_in();
    rst_n   = 1'b1;
    run_chk = 1'b1;

    // nominal frequency
    run_ticks(25);
    // small positive and negative corrections
    ferr = 24'sd1000;
    run_ticks(30);
    ferr = -24'sd2000;
    run_ticks(30);
    // R5 upper clamp
    ferr = 24'sd8000000;
    run_ticks(30);
    @(negedge clk);
    chk("R5 upper clamp", longint'(ftw), longint'(fmax), 0);
    // R5 lower clamp
    step_in();
    ferr = -24'sd8000000;
    run_ticks(30);
    @(negedge clk);
    chk("R5 lower clamp", longint'(ftw), longint'(fmin), 0);
    // wide range: large base phase, harmonic phases wrap (R7)
    step_in();
    fmax = 32'h8000_0000;
    ferr = 24'sd8000000;
    run_ticks(200);
    // R4 error changes on every clock, only update ticks count
    fmax = 32'd279172;
    for (int i = 0; i < 5000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      ferr = 24'(int'((seed >> 8) % 32'd4001) - 2000);
      step_in();
    end
    // reset in mid-run returns to nominal (R3)
    rst_n   = 1'b0;
    run_chk = 1'b0;
    #1;
    reset_checks();
    repeat (3) @(posedge clk);
    #1;
    ferr    = 24'sd500;
    rst_n   = 1'b1;
    run_chk = 1'b1;
    run_ticks(20);
    summary();
    $finish;
  end

endmodule